// File: doc/BRIEF.md
# Interpolating Start-Stop Interval Converter

This block measures the time from a start event to a stop event with a resolution finer than one system clock period. A tapped delay line sits in front of each event input. For each event it captures a thermometer snapshot that shows how far the edge ran down the line before the next clock edge sampled it. The block turns each snapshot into a fine code. A coarse counter on the system clock counts the whole periods between the start-sampling edge and the stop-sampling edge. The interval word is start fine code plus the coarse count times the number of taps per period, minus the stop fine code. All quantities are in fine bins.

Each finished result is offered on a valid/ready output and held until it is taken. After the hand-off the converter stays deaf to new start events for a dead time of about 20 ns before it re-arms. If no stop arrives before the saturating coarse counter reaches its limit, the result is flagged as an overflow.

Top module: `tdc_interval`

## Requirements
- R1: After synchronous reset, `res_valid_o` and `res_overflow_o` are 0.
- R2: A start sampled at clock edge E0 and a stop sampled at edge Ek (k >= 1) give `res_interval_o` = fs + k*THERM_W - fp. Here fs and fp are the start and stop fine codes, and THERM_W (default 24) is the number of taps, equal to the number of fine bins per clock period.
- R3: With ENC_MODE = 0, a fine code is the length of the unbroken run of ones starting at tap bit 0. Any one bit above the first zero is ignored.
- R4: With ENC_MODE = 1, a fine code is the total number of ones in the snapshot.
- R5: `res_valid_o` rises after edge Ek+1, where Ek is the stop-sampling edge. Before that edge it is 0.
- R6: While `res_valid_o` is 1 and `res_ready_i` is 0, the result holds stable. An edge that samples both valid and ready high clears `res_valid_o`.
- R7: A stop event while the converter is idle has no effect.
- R8: A start event while a measurement is in progress does not restart it.
- R9: The dead time is DEAD_CYC = ceil(DEAD_PS/CLK_PS) edges (default 3) after the accepting edge. Start events sampled during the dead time are ignored. A start at the next edge is accepted.
- R10: The coarse limit is CMAX = 2^COARSE_W - 1 (default 63). If no stop is sampled by the edge at which the count reaches CMAX, the result is delivered with `res_overflow_o` = 1 and `res_interval_o` all ones. A stop sampled at that edge is measured normally with k = CMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start event seen at this edge |
| start_taps_i | input | THERM_W | Start delay-line snapshot |
| stop_i | input | 1 | Stop event seen at this edge |
| stop_taps_i | input | THERM_W | Stop delay-line snapshot |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_valid_o | output | 1 | Result available |
| res_interval_o | output | OUT_W | Interval in fine bins |
| res_overflow_o | output | 1 | No stop within coarse range |

## Verification
Counting from the edge that samples the stop, the stop code is registered at that edge. The interval is registered one edge later, so the bench reads the output at the falling edge that follows edge Ek+1. It also confirms that valid is still low one falling edge earlier. An overflow follows the same pattern: it lands one edge after the count limit is reached. The dead time is measured from the accepting edge. Every stimulus is placed on a falling edge and counted in whole edges. This puts the first permitted start exactly DEAD_CYC+1 edges after acceptance and a forbidden one exactly at edge DEAD_CYC.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_CALC = 3'd2,
    ST_HOLD = 3'd3,
    ST_DEAD = 3'd4
  } tdc_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/tdc_therm_enc.sv
module tdc_therm_enc #(
  parameter int THERM_W  = 24,
  parameter int FINE_W   = 8,
  parameter int ENC_MODE = 0
) (
  input  logic [THERM_W-1:0] taps_i,
  output logic [FINE_W-1:0]  code_o
);

  generate
    if (ENC_MODE == 0) begin : g_run
      // Length of the run of ones from bit 0; bubbles above the first zero drop out.
      always_comb begin
        logic alive;
        int   n;
        alive = 1'b1;
        n     = 0;
        for (int i = 0; i < THERM_W; i++) begin
          if (alive && taps_i[i]) n = n + 1;
          else                    alive = 1'b0;
        end
        code_o = FINE_W'(n);
      end
    end else begin : g_pop
      // Total population; a bubble shifts the code by at most one bin.
      always_comb begin
        int n;
        n = 0;
        for (int i = 0; i < THERM_W; i++) begin
          if (taps_i[i]) n = n + 1;
        end
        code_o = FINE_W'(n);
      end
    end
  endgenerate

endmodule

// File: rtl/tdc_combine.sv
module tdc_combine #(
  parameter int THERM_W  = 24,
  parameter int FINE_W   = 8,
  parameter int COARSE_W = 6,
  parameter int OUT_W    = 11
) (
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_start_i,
  input  logic [FINE_W-1:0]   fine_stop_i,
  output logic [OUT_W-1:0]    interval_o
);

  localparam logic [OUT_W-1:0] BINS = OUT_W'(THERM_W);

  logic [OUT_W-1:0] scaled;
  logic [OUT_W-1:0] with_start;

  // coarse >= 1 and fine codes <= BINS, so the subtraction never wraps.
  always_comb begin
    scaled     = OUT_W'(coarse_i) * BINS;
    with_start = scaled + OUT_W'(fine_start_i);
    interval_o = with_start - OUT_W'(fine_stop_i);
  end

endmodule

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
  import tdc_pkg::*;
#(
  parameter int FINE_W   = 8,
  parameter int COARSE_W = 6,
  parameter int OUT_W    = 11,
  parameter int DEAD_CYC = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [FINE_W-1:0]   start_code_i,
  input  logic                stop_i,
  input  logic [FINE_W-1:0]   stop_code_i,
  input  logic [OUT_W-1:0]    sum_i,
  input  logic                res_ready_i,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_start_o,
  output logic [FINE_W-1:0]   fine_stop_o,
  output logic                res_valid_o,
  output logic [OUT_W-1:0]    res_interval_o,
  output logic                res_overflow_o
);

  localparam logic [COARSE_W-1:0] CMAX   = '1;
  localparam int                  DCNT_W = $clog2(DEAD_CYC + 1);
  localparam logic [DCNT_W-1:0]   DLOAD  = DCNT_W'(DEAD_CYC - 1);

  tdc_state_e        state;
  logic [DCNT_W-1:0] dcnt;
  logic              ovf_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      coarse_o       <= '0;
      fine_start_o   <= '0;
      fine_stop_o    <= '0;
      ovf_pend       <= 1'b0;
      dcnt           <= '0;
      res_valid_o    <= 1'b0;
      res_interval_o <= '0;
      res_overflow_o <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            fine_start_o <= start_code_i;
            fine_stop_o  <= '0;
            coarse_o     <= COARSE_W'(1);
            ovf_pend     <= 1'b0;
            state        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (stop_i) begin
            fine_stop_o <= stop_code_i;
            state       <= ST_CALC;
          end else if (coarse_o == CMAX) begin
            ovf_pend <= 1'b1;
            state    <= ST_CALC;
          end else begin
            coarse_o <= coarse_o + COARSE_W'(1);
          end
        end
        ST_CALC: begin
          res_interval_o <= ovf_pend ? '1 : sum_i;
          res_overflow_o <= ovf_pend;
          res_valid_o    <= 1'b1;
          state          <= ST_HOLD;
        end
        ST_HOLD: begin
          if (res_ready_i) begin
            res_valid_o    <= 1'b0;
            res_overflow_o <= 1'b0;
            dcnt           <= DLOAD;
            state          <= ST_DEAD;
          end
        end
        ST_DEAD: begin
          if (dcnt == '0) state <= ST_IDLE;
          else            dcnt  <= dcnt - DCNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tdc_interval.sv
module tdc_interval
  import tdc_pkg::*;
#(
  parameter int THERM_W  = 24,
  parameter int FINE_W   = 8,
  parameter int COARSE_W = 6,
  parameter int ENC_MODE = 0,
  parameter int CLK_PS   = 8000,
  parameter int DEAD_PS  = 20000,
  parameter int OUT_W    = $clog2(((1 << COARSE_W) - 1) * THERM_W + THERM_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [THERM_W-1:0] start_taps_i,
  input  logic               stop_i,
  input  logic [THERM_W-1:0] stop_taps_i,
  input  logic               res_ready_i,
  output logic               res_valid_o,
  output logic [OUT_W-1:0]   res_interval_o,
  output logic               res_overflow_o
);

  localparam int DEAD_RAW = ceil_div(DEAD_PS, CLK_PS);
  localparam int DEAD_CYC = (DEAD_RAW < 1) ? 1 : DEAD_RAW;

  logic [FINE_W-1:0]   start_code, stop_code;
  logic [FINE_W-1:0]   fine_start, fine_stop;
  logic [COARSE_W-1:0] coarse;
  logic [OUT_W-1:0]    sum;

  tdc_therm_enc #(.THERM_W(THERM_W), .FINE_W(FINE_W), .ENC_MODE(ENC_MODE)) u_enc_start (
    .taps_i (start_taps_i),
    .code_o (start_code)
  );

  tdc_therm_enc #(.THERM_W(THERM_W), .FINE_W(FINE_W), .ENC_MODE(ENC_MODE)) u_enc_stop (
    .taps_i (stop_taps_i),
    .code_o (stop_code)
  );

  tdc_combine #(.THERM_W(THERM_W), .FINE_W(FINE_W), .COARSE_W(COARSE_W), .OUT_W(OUT_W)) u_comb (
    .coarse_i     (coarse),
    .fine_start_i (fine_start),
    .fine_stop_i  (fine_stop),
    .interval_o   (sum)
  );

  tdc_ctrl #(.FINE_W(FINE_W), .COARSE_W(COARSE_W), .OUT_W(OUT_W), .DEAD_CYC(DEAD_CYC)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .start_code_i   (start_code),
    .stop_i         (stop_i),
    .stop_code_i    (stop_code),
    .sum_i          (sum),
    .res_ready_i    (res_ready_i),
    .coarse_o       (coarse),
    .fine_start_o   (fine_start),
    .fine_stop_o    (fine_stop),
    .res_valid_o    (res_valid_o),
    .res_interval_o (res_interval_o),
    .res_overflow_o (res_overflow_o)
  );

endmodule

// File: rtl/tdc_interval_chk.sv
module tdc_interval_chk #(
  parameter int OUT_W    = 11,
  parameter int DEAD_CYC = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [OUT_W-1:0] res_interval_o,
  input logic             res_overflow_o
);

  logic [7:0] since_acc;

  always_ff @(posedge clk) begin
    if (rst)                             since_acc <= 8'hFF;
    else if (res_valid_o && res_ready_i) since_acc <= 8'd0;
    else if (since_acc != 8'hFF)         since_acc <= since_acc + 8'd1;
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_interval_o) && $stable(res_overflow_o)));

  // R6
  accept_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && res_ready_i) |=> !res_valid_o);

  // R10
  ovf_value_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && res_overflow_o) |-> (res_interval_o == '1));

  // R1
  ovf_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid_o |-> !res_overflow_o);

  // R9
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid_o) |-> (since_acc >= 8'(DEAD_CYC + 3)));

endmodule

bind tdc_interval tdc_interval_chk #(.OUT_W(OUT_W), .DEAD_CYC(DEAD_CYC)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .res_valid_o    (res_valid_o),
  .res_ready_i    (res_ready_i),
  .res_interval_o (res_interval_o),
  .res_overflow_o (res_overflow_o)
);

// File: tb/tb_tdc_interval.sv
module tb_tdc_interval;

  localparam int TW   = 24;
  localparam int OW   = 11;
  localparam int DEAD = 3;
  localparam int CMAX = 63;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0, stop_i = 1'b0, ready = 1'b0;
  logic [TW-1:0] start_taps = '0, stop_taps = '0;
  logic          v0, v1, o0, o1;
  logic [OW-1:0] iv0, iv1;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tdc_interval #(.ENC_MODE(0)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_taps_i(start_taps),
    .stop_i(stop_i), .stop_taps_i(stop_taps), .res_ready_i(ready),
    .res_valid_o(v0), .res_interval_o(iv0), .res_overflow_o(o0));

  tdc_interval #(.ENC_MODE(1)) dut_pop (
    .clk(clk), .rst(rst), .start_i(start_i), .start_taps_i(start_taps),
    .stop_i(stop_i), .stop_taps_i(stop_taps), .res_ready_i(ready),
    .res_valid_o(v1), .res_interval_o(iv1), .res_overflow_o(o1));

  localparam int NV = 8;
  localparam int V_FS [NV] = '{0, 24, 5, 24, 10, 0, 24, 7};
  localparam int V_FP [NV] = '{0, 0, 20, 24, 3, 24, 0, 7};
  localparam int V_K  [NV] = '{1, 1, 1, 2, 5, 1, 10, 3};
  localparam int V_RE [NV] = '{0, 0, 0, 0, 2, 0, 4, 0};

  function automatic logic [TW-1:0] therm(input int n);
    logic [63:0] w;
    w = (64'd1 << n) - 64'd1;
    return w[TW-1:0];
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Start at edge E0, stop at Ek, result read after Ek+1, then accept and sit out the dead time.
  task automatic measure(input logic [TW-1:0] sv, input logic [TW-1:0] pv, input int k,
                         input int re, input int e0, input int e1, input bit probe);
    @(negedge clk);
    start_i = 1'b1; start_taps = sv;
    @(negedge clk);
    start_i = 1'b0;
    for (int j = 1; j < k; j++) begin
      if (j == re) begin start_i = 1'b1; start_taps = '1; end  // R8 extra start
      @(negedge clk);
      start_i = 1'b0;
    end
    stop_i = 1'b1; stop_taps = pv;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R5 valid low before Ek+1", v0, 0);
    @(negedge clk);
    chk("R5 valid after Ek+1", v0, 1);
    chk("R2/R3/R8 interval run mode", iv0, e0);
    chk("R4 interval popcount mode", iv1, e1);
    chk("R10 no overflow", o0, 0);
    @(negedge clk);
    chk("R6 held valid", v0, 1);
    chk("R6 held interval", iv0, e0);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk("R6 valid cleared on accept", v0, 0);
    if (probe) begin
      repeat (DEAD - 1) @(negedge clk);
      start_i = 1'b1; start_taps = therm(4);   // sampled at the last dead edge
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      repeat (6) @(negedge clk);
      chk("R9 start in dead time ignored", v0, 0);
    end else begin
      repeat (DEAD) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", v0, 0);
    chk("R1 overflow in reset", o0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", v0, 0);

    for (int i = 0; i < NV; i++) begin
      int e;
      e = V_K[i] * TW + V_FS[i] - V_FP[i];
      measure(therm(V_FS[i]), therm(V_FP[i]), V_K[i], V_RE[i], e, e, 1'b0);
    end

    // R7: stop while idle
    stop_i = 1'b1; stop_taps = therm(5);
    @(negedge clk);
    stop_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 idle stop ignored", v0, 0);

    // R3/R4: bubble above the run: start run 3 + bit 5, stop run 10
    measure(therm(3) | (TW'(1) << 5), therm(10), 2, 0, 2*TW + 3 - 10, 2*TW + 4 - 10, 1'b0);

    // R9: start at the last dead edge ignored, then a normal measurement
    measure(therm(6), therm(2), 1, 0, TW + 4, TW + 4, 1'b1);
    measure(therm(9), therm(1), 4, 0, 4*TW + 8, 4*TW + 8, 1'b0);

    // R10: stop exactly at the coarse limit is measured normally
    measure(therm(2), therm(1), CMAX, 0, CMAX*TW + 1, CMAX*TW + 1, 1'b0);

    // R10: no stop at all
    @(negedge clk);
    start_i = 1'b1; start_taps = therm(3);
    @(negedge clk);
    start_i = 1'b0;
    repeat (CMAX) @(negedge clk);
    chk("R10 valid low before overflow result", v0, 0);
    @(negedge clk);
    chk("R10 overflow valid", v0, 1);
    chk("R10 overflow flag", o0, 1);
    chk("R10 overflow value", iv0, (1 << OW) - 1);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk("R6 overflow cleared on accept", o0, 0);
    repeat (DEAD) @(negedge clk);
    measure(therm(12), therm(12), 1, 0, TW, TW, 1'b0);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

endmodule